// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Slave

This block is an I2C-compatible target that gives a bus master access to a small bank of byte registers through an internal sub-address pointer. A fast system clock oversamples SCL and SDA. The block recognises start, repeated start and stop conditions and answers one fixed 7-bit device address. It pulls SDA low through an output-enable signal and never drives the line high.

To write, the master sends the device address with the direction bit clear. The first byte that follows sets the pointer. Every later byte goes to the register the pointer selects, and the pointer then advances. To read, the master sends the address with the direction bit set, and the block returns the register at the pointer. Each master acknowledge advances the pointer and sends the next register.

The pointer survives a repeated start, so a write that only sets the pointer can be followed directly by a read. A stop returns the pointer to zero, so a master can poll location 0 (a status byte taken from an input port) without setting the pointer again. Each byte that is stored also produces a one-cycle write pulse with its address and data.

Top module: `i2c_ptr_slave`

## Requirements
- R1: A falling SDA while SCL is high (start or repeated start) abandons any transfer in progress. It begins a new 8-bit address phase, sampled MSB first on rising SCL.
- R2: When the upper seven bits of the address byte equal 0x48, the block pulls SDA low during the ninth SCL pulse. Any other address gets no acknowledge, and the block stays silent until the next start.
- R3: In a write (bit 0 of the address byte = 0), the first data byte is loaded into the pointer. Each later byte is acknowledged, written to the register at the pointer, and then the pointer advances by one.
- R4: In a read (bit 0 = 1), the byte at the pointer is sent MSB first. When the master acknowledges (SDA low in the ninth pulse), the pointer advances and the next byte is sent.
- R5: When the master does not acknowledge a read byte, the block goes idle and the pointer keeps its value.
- R6: A rising SDA while SCL is high (stop) sends the block idle and clears the pointer to 0x00.
- R7: The pointer keeps its value across a repeated start.
- R8: Location 0x00 reads the `status_in` port. Writes to it are acknowledged but store nothing and produce no write pulse.
- R9: Writes to locations 0x14 and above are acknowledged and dropped. Reads from those locations return 0x00. The 8-bit pointer wraps from 0xFF to 0x00.
- R10: Each stored byte produces exactly one `wr_stb` cycle, carrying its location on `wr_addr` and its value on `wr_data`.
- R11: `sda_oe` is low after reset and while the block is idle, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| status_in | input | 8 | Value returned for location 0x00 |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_addr | output | 8 | Location of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
The bench builds the block with its defaults: device address 0x48, twenty locations and two synchronizer stages. Twenty locations put the last writable location, 0x13, next to the first invalid one. One two-byte burst therefore covers both a stored write and a dropped write, and one read covers a stored byte followed by a 0x00 filler. The 8-bit pointer lets a read starting at 0xFF wrap to the status location within a single burst. Two synchronizer stages keep the SDA response three to four clocks behind each SCL edge, well inside the bench's sixteen-clock half bit.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int PTR_W  = 8;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [3:0]        bits;
        logic [DATA_W-1:0] sh;
        logic [PTR_W-1:0]  ptr;
        logic              rw;
        logic              first;
        logic              oe;
        logic              stb;
        logic [PTR_W-1:0]  waddr;
        logic [DATA_W-1:0] wdata;
    } ctrl_s;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sr_q <= {scl_sr_q[STAGES-2:0], scl_in};
            sda_sr_q <= {sda_sr_q[STAGES-2:0], sda_in};
            scl_p_q  <= scl_sr_q[STAGES-1];
            sda_p_q  <= sda_sr_q[STAGES-1];
        end
    end

    assign scl_s    = scl_sr_q[STAGES-1];
    assign sda_s    = sda_sr_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_p_q;
    assign scl_fall = ~scl_s & scl_p_q;
    assign start    = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop     = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile
    import i2cs_pkg::*;
#(
    parameter int NUM_REGS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] status_in,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_REGS);

    logic [NUM_REGS*DATA_W-1:0] flat;
    assign flat[DATA_W-1:0] = status_in;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_cell
        logic [DATA_W-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= '0;
            else if (wr_en && wr_addr == PTR_W'(g))
                r_q <= wr_data;
        end
        assign flat[g*DATA_W +: DATA_W] = r_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == PTR_W'(i))
                rd_data = flat[i*DATA_W +: DATA_W];
    end

    // R8, R9: only writable locations may be strobed
    assert_wr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != '0 && wr_addr < TOP));
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         NUM_REGS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    input  logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_addr,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_REGS);

    ctrl_s d, q;

    always_comb begin
        d       = q;
        d.stb   = 1'b0;
        rd_addr = (q.st == ST_TX_ACK) ? q.ptr + 1'b1 : q.ptr;
        if (stop) begin
            d.st   = ST_IDLE;
            d.ptr  = '0;
            d.oe   = 1'b0;
            d.bits = '0;
        end else if (start) begin
            d.st   = ST_ADDR;
            d.bits = '0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[DATA_W-2:0], sda_s};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.st    = ST_ADDR_ACK;
                                d.oe    = 1'b1;
                                d.rw    = q.sh[0];
                                d.first = 1'b1;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st = ST_RX_ACK;
                            d.oe = 1'b1;
                            if (q.first) begin
                                d.ptr   = q.sh;
                                d.first = 1'b0;
                            end else begin
                                d.ptr = q.ptr + 1'b1;
                                if (q.ptr != '0 && q.ptr < TOP) begin
                                    d.stb   = 1'b1;
                                    d.waddr = q.ptr;
                                    d.wdata = q.sh;
                                end
                            end
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    d.bits = '0;
                    if (q.rw) begin
                        d.st = ST_TX;
                        d.sh = rd_data;
                        d.oe = ~rd_data[DATA_W-1];
                    end else begin
                        d.st = ST_RX;
                        d.oe = 1'b0;
                    end
                end
                ST_RX_ACK: if (scl_fall) begin
                    d.st   = ST_RX;
                    d.bits = '0;
                    d.oe   = 1'b0;
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bits == 4'd8) begin
                            d.st = ST_TX_ACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh = {q.sh[DATA_W-2:0], 1'b0};
                            d.oe = ~q.sh[DATA_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_s) begin
                        d.st = ST_IDLE;
                    end else if (scl_fall) begin
                        d.ptr  = q.ptr + 1'b1;
                        d.sh   = rd_data;
                        d.oe   = ~rd_data[DATA_W-1];
                        d.bits = '0;
                        d.st   = ST_TX;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bits: '0, sh: '0, ptr: '0, rw: 1'b0, first: 1'b0,
                   oe: 1'b0, stb: 1'b0, waddr: '0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_stb  = q.stb;
    assign wr_addr = q.waddr;
    assign wr_data = q.wdata;

    assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !scl_s);
    assert_stop_clears_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (q.ptr == '0 && q.st == ST_IDLE));
    assert_start_to_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stop) |=> q.st == ST_ADDR);
    assert_nack_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX_ACK && scl_rise && sda_s && !start && !stop)
            |=> ($stable(q.ptr) && q.st == ST_IDLE));
    assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb);
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NUM_REGS    = 20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [DATA_W-1:0] status_in,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic [PTR_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start(start), .stop(stop)
    );

    i2cs_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start(start), .stop(stop),
        .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    i2cs_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .status_in(status_in),
        .rd_data(rd_data)
    );
endmodule

// File: tb/i2c_ptr_slave_test.sv
module i2c_ptr_slave_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe, wr_stb;
    logic [7:0] wr_addr, wr_data;
    logic [7:0] status = 8'h5A;

    assign sda_line = sda_m & ~sda_oe;

    i2c_ptr_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .status_in(status), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0, fails = 0, stb_cnt = 0, oe_viol = 0;
    logic [7:0] last_a = '0, last_d = '0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_a <= wr_addr;
            last_d <= wr_data;
        end
        if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt();
        repeat (16) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); sda_m = 1'b0; wt(); scl_m = 1'b0; wt();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(); scl_m = 1'b1; wt(); sda_m = 1'b1; wt();
    endtask

    task automatic put_bit(input bit b);
        sda_m = b; wt(); scl_m = 1'b1; wt(); scl_m = 1'b0; wt();
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wt(); scl_m = 1'b1; wt(); b = sda_line; scl_m = 1'b0; wt();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!ack);
    endtask

    task automatic t_reset();
        check(sda_oe == 1'b0, "R11 reset oe", sda_oe, 0);
        check(wr_stb == 1'b0, "R10 reset stb", wr_stb, 0);
    endtask

    task automatic t_write_burst();
        bit a; int s0;
        bus_start();
        send_byte(8'h90, a); check(a, "R2 write addr ack", a, 1);
        send_byte(8'h03, a); check(a, "R3 pointer ack", a, 1);
        s0 = stb_cnt;
        send_byte(8'hA1, a); check(a, "R3 data ack", a, 1);
        send_byte(8'hB2, a);
        send_byte(8'hC3, a); check(a, "R3 third ack", a, 1);
        bus_stop();
        check(stb_cnt - s0 == 3, "R10 strobe count", stb_cnt - s0, 3);
        check(last_a == 8'h05, "R10 last addr", last_a, 8'h05);
        check(last_d == 8'hC3, "R10 last data", last_d, 8'hC3);
    endtask

    task automatic t_read_burst();
        bit a; logic [7:0] v;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h03, a);
        bus_start();
        send_byte(8'h91, a); check(a, "R2 read addr ack", a, 1);
        recv_byte(1'b1, v); check(v == 8'hA1, "R7 ptr kept over restart", v, 8'hA1);
        recv_byte(1'b1, v); check(v == 8'hB2, "R4 incr on ack", v, 8'hB2);
        recv_byte(1'b0, v); check(v == 8'hC3, "R4 third byte", v, 8'hC3);
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b0, v); check(v == 8'hC3, "R5 nack keeps ptr", v, 8'hC3);
        bus_stop();
    endtask

    task automatic t_stop_reset();
        bit a; logic [7:0] v;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h04, a);
        bus_stop();
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b0, v); check(v == 8'h5A, "R6 stop clears ptr", v, 8'h5A);
        bus_stop();
        check(sda_oe == 1'b0, "R11 idle oe", sda_oe, 0);
    endtask

    task automatic t_bad_addr();
        bit a; logic [7:0] v; int s0;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h92, a); check(!a, "R2 foreign addr nack", a, 0);
        send_byte(8'h00, a); check(!a, "R2 silent after mismatch", a, 0);
        bus_stop();
        check(stb_cnt == s0, "R2 no write", stb_cnt - s0, 0);
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(8'h91, a); check(a, "R1 restart mid byte", a, 1);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic t_status_ro();
        bit a; logic [7:0] v; int s0;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h00, a);
        send_byte(8'h77, a); check(a, "R8 ro write acked", a, 1);
        bus_stop();
        check(stb_cnt == s0, "R8 no strobe", stb_cnt - s0, 0);
        status = 8'h3C;
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b0, v); check(v == 8'h3C, "R8 status port", v, 8'h3C);
        bus_stop();
    endtask

    task automatic t_invalid();
        bit a; logic [7:0] v; int s0;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h13, a);
        s0 = stb_cnt;
        send_byte(8'h11, a);
        send_byte(8'h22, a); check(a, "R9 invalid write acked", a, 1);
        bus_stop();
        check(stb_cnt - s0 == 1, "R9 one strobe", stb_cnt - s0, 1);
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h13, a);
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b1, v); check(v == 8'h11, "R9 last valid", v, 8'h11);
        recv_byte(1'b0, v); check(v == 8'h00, "R9 out of range reads 0", v, 8'h00);
        bus_stop();
    endtask

    task automatic t_wrap();
        bit a; logic [7:0] v;
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b1, v); check(v == 8'h00, "R9 loc ff", v, 8'h00);
        recv_byte(1'b0, v); check(v == 8'h3C, "R9 wrap to status", v, 8'h3C);
        bus_stop();
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_burst();
        t_read_burst();
        t_stop_reset();
        t_bad_addr();
        t_status_ro();
        t_invalid();
        t_wrap();
        check(oe_viol == 0, "R11 oe moved with scl high", oe_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule